// File: doc/BRIEF.md
# Unaligned Burst Beat Generator

This block sits on the master side of a memory-mapped bus. It takes one software transfer request and turns it into a single incrementing write burst. A request carries four things: a start byte address, which may be unaligned; a byte count; a beat size code; and a flag that marks the request as wrap-type. The block works out how many beats the burst needs. It then sends out one beat at a time, each with its beat address, a byte-lane strobe mask and a final-beat marker. The strobe mask enables only the bytes that the request actually asked for.

When the start address is not aligned to the beat size, the first beat and the last beat both carry partial strobes. The count also includes the extra beat that straddles the end. For example, 16 bytes from address 0x01 with 4-byte beats give five beats, with strobes 0xE, 0xF, 0xF, 0xF and 0x1. The block refuses three kinds of request: a request with no bytes, a size wider than the bus, and a wrap-type request with a misaligned start. For each refusal it raises an error pulse and sends no beats.

Both sides use valid/ready handshakes. The block takes at most one request at a time and accepts the next one only after the final beat of the current burst has been handed over.

Top module: `burst_beat_gen`

## Requirements
- R1: The number of beats is (start mod size + byte count + size - 1) / size, where size = 2^req_size bytes.
- R2: The first beat's address is the start address itself. Its strobe enables the lanes from the start byte to the lesser of the last requested byte and the end of the size-aligned unit that holds the start.
- R3: Each beat after the first is addressed at the previous beat address, rounded down to a size boundary, plus size.
- R4: Strobe bit i of a beat is set exactly when the byte whose address has i as its value mod BUS_BYTES is inside the requested range and inside that beat's size window. A middle beat therefore enables size consecutive lanes.
- R5: beat_last is high on the final beat of a burst and low on every other beat.
- R6: req_ready is high only while no burst is pending. A stalled beat holds its address, strobe and marker steady. req_ready returns high in the cycle after the final beat is handed over.
- R7: A request with a byte count of zero is refused: req_err is high for one cycle after the accepting edge and no beat follows.
- R8: A wrap-type request (req_wrap=1) whose start address is not a multiple of size is refused in the same way as R7.
- R9: A request whose size code is above log2(BUS_BYTES) is refused in the same way as R7.
- R10: A wrap-type request with an aligned start gives the same beat sequence as an incrementing request.
- R11: During and just after reset, req_ready=1, beat_valid=0 and req_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Total byte count |
| req_size | input | SZ_W | Beat size code, bytes = 2^code |
| req_wrap | input | 1 | Request is wrap-type |
| req_err | output | 1 | One-cycle pulse for a refused request |
| beat_valid | output | 1 | Beat on offer |
| beat_ready | input | 1 | Downstream takes the beat |
| beat_addr | output | ADDR_W | Beat address |
| beat_strb | output | BUS_BYTES | Byte-lane enable mask |
| beat_last | output | 1 | Final beat of the burst |

## Verification
The main function is driven with four kinds of request. An unaligned word burst that straddles a word boundary tells apart the partial first and last strobes and the extra beat. An aligned burst tells apart full strobes with no extra beat. Byte and halfword bursts from odd addresses show that the lane position follows the address modulo the bus width and not the beat index. A single byte in the middle of a word shows a burst whose first beat is also its last. Each burst runs once with the downstream always ready and once with random stalls, which separates address stepping from stall holding. The refused cases (empty, too wide, misaligned wrap) are set against an aligned wrap request and against requests held valid back to back.

// File: rtl/bbg_pkg.sv
package bbg_pkg;

  typedef enum logic [1:0] {
    REJ_NONE      = 2'd0,
    REJ_EMPTY     = 2'd1,
    REJ_WIDE      = 2'd2,
    REJ_WRAP_MIS  = 2'd3
  } rej_cause_e;

  typedef enum logic {
    GEN_IDLE  = 1'b0,
    GEN_BURST = 1'b1
  } gen_state_e;

  // low-bit mask of a size-aligned unit: 2^s - 1
  function automatic logic [31:0] unit_mask(input logic [4:0] s);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 32; b++) begin
      if (b < int'(s)) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/bbg_req_check.sv
module bbg_req_check import bbg_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10,
  parameter int SZ_W   = 3,
  parameter int LANE_W = 2,
  parameter int CNT_W  = LEN_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [SZ_W-1:0]   size,
  input  logic              wrap,
  output rej_cause_e        cause,
  output logic [CNT_W-1:0]  beat_cnt,
  output logic [ADDR_W-1:0] last_byte
);
  localparam int SUM_W = LEN_W + 2;

  function automatic logic [CNT_W-1:0] beats_for(
    input logic [LANE_W-1:0] offs,
    input logic [LEN_W-1:0]  n,
    input logic [SZ_W-1:0]   s,
    input logic [LANE_W-1:0] m
  );
    logic [SUM_W-1:0] span;
    span = SUM_W'(offs) + SUM_W'(n) + SUM_W'(m);
    return CNT_W'(span >> s);
  endfunction

  logic [LANE_W-1:0] lane_m;
  logic [LANE_W-1:0] start_offs;
  logic              misaligned;

  assign lane_m     = LANE_W'(unit_mask(5'(size)));
  assign start_offs = addr[LANE_W-1:0] & lane_m;
  assign misaligned = |start_offs;
  assign beat_cnt   = beats_for(start_offs, len, size, lane_m);
  assign last_byte  = addr + ADDR_W'(len) - ADDR_W'(1);

  always_comb begin
    if (len == '0)                    cause = REJ_EMPTY;
    else if (size > SZ_W'(LANE_W))    cause = REJ_WIDE;
    else if (wrap && misaligned)      cause = REJ_WRAP_MIS;
    else                              cause = REJ_NONE;
  end
endmodule

// File: rtl/bbg_addr_step.sv
module bbg_addr_step import bbg_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 3
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [SZ_W-1:0]   size,
  output logic [ADDR_W-1:0] next_addr
);
  function automatic logic [ADDR_W-1:0] advance(
    input logic [ADDR_W-1:0] a,
    input logic [SZ_W-1:0]   s
  );
    logic [ADDR_W-1:0] m;
    m = ADDR_W'(unit_mask(5'(s)));
    return (a & ~m) + (m + ADDR_W'(1));
  endfunction

  assign next_addr = advance(cur_addr, size);
endmodule

// File: rtl/bbg_strb_gen.sv
module bbg_strb_gen import bbg_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int BUS_BYTES = 4,
  parameter int SZ_W      = 3,
  parameter int LANE_W    = 2
) (
  input  logic [ADDR_W-1:0]    cur_addr,
  input  logic [ADDR_W-1:0]    last_byte,
  input  logic [SZ_W-1:0]      size,
  output logic [BUS_BYTES-1:0] strb
);
  logic [ADDR_W-1:0] win_hi;

  function automatic logic [ADDR_W-1:0] window_top(
    input logic [ADDR_W-1:0] a,
    input logic [SZ_W-1:0]   s
  );
    logic [ADDR_W-1:0] m;
    m = ADDR_W'(unit_mask(5'(s)));
    return a | m;
  endfunction

  assign win_hi = window_top(cur_addr, size);

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    assign lane_addr = {cur_addr[ADDR_W-1:LANE_W], LANE_W'(i)};
    assign strb[i]   = (lane_addr >= cur_addr) && (lane_addr <= win_hi) &&
                       (lane_addr <= last_byte);
  end
endmodule

// File: rtl/burst_beat_gen.sv
module burst_beat_gen import bbg_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 10,
  parameter int BUS_BYTES = 4,
  parameter int SZ_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [SZ_W-1:0]      req_size,
  input  logic                 req_wrap,
  output logic                 req_err,
  output logic                 beat_valid,
  input  logic                 beat_ready,
  output logic [ADDR_W-1:0]    beat_addr,
  output logic [BUS_BYTES-1:0] beat_strb,
  output logic                 beat_last
);
  localparam int LANE_W = $clog2(BUS_BYTES);
  localparam int CNT_W  = LEN_W + 1;

  gen_state_e        state_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [ADDR_W-1:0] last_byte_q;
  logic [SZ_W-1:0]   size_q;
  logic [CNT_W-1:0]  left_q;
  logic              err_q;

  rej_cause_e        chk_cause;
  logic [CNT_W-1:0]  chk_cnt;
  logic [ADDR_W-1:0] chk_last;
  logic [ADDR_W-1:0] step_addr;

  // named events
  logic req_fire, rej_fire, load_fire, beat_fire, final_beat, burst_done;

  bbg_req_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SZ_W(SZ_W), .LANE_W(LANE_W), .CNT_W(CNT_W)
  ) u_check (
    .addr(req_addr), .len(req_len), .size(req_size), .wrap(req_wrap),
    .cause(chk_cause), .beat_cnt(chk_cnt), .last_byte(chk_last)
  );

  bbg_addr_step #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_step (
    .cur_addr(cur_addr_q), .size(size_q), .next_addr(step_addr)
  );

  bbg_strb_gen #(
    .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .SZ_W(SZ_W), .LANE_W(LANE_W)
  ) u_strb (
    .cur_addr(cur_addr_q), .last_byte(last_byte_q), .size(size_q), .strb(beat_strb)
  );

  assign req_ready  = (state_q == GEN_IDLE);
  assign beat_valid = (state_q == GEN_BURST);
  assign req_fire   = req_valid && req_ready;
  assign rej_fire   = req_fire && (chk_cause != REJ_NONE);
  assign load_fire  = req_fire && (chk_cause == REJ_NONE);
  assign final_beat = (left_q == CNT_W'(1));
  assign beat_fire  = beat_valid && beat_ready;
  assign burst_done = beat_fire && final_beat;

  assign beat_addr  = cur_addr_q;
  assign beat_last  = beat_valid && final_beat;
  assign req_err    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= GEN_IDLE;
      cur_addr_q  <= '0;
      last_byte_q <= '0;
      size_q      <= '0;
      left_q      <= '0;
      err_q       <= 1'b0;
    end else begin
      err_q <= rej_fire;
      if (load_fire) begin
        state_q     <= GEN_BURST;
        cur_addr_q  <= req_addr;
        last_byte_q <= chk_last;
        size_q      <= req_size;
        left_q      <= chk_cnt;
      end else if (beat_fire) begin
        if (final_beat) begin
          state_q <= GEN_IDLE;
        end else begin
          cur_addr_q <= step_addr;
          left_q     <= left_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bbg_checker.sv
module bbg_checker #(
  parameter int ADDR_W    = 16,
  parameter int BUS_BYTES = 4,
  parameter int SZ_W      = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic                 req_err,
  input logic                 beat_valid,
  input logic                 beat_ready,
  input logic [ADDR_W-1:0]    beat_addr,
  input logic [BUS_BYTES-1:0] beat_strb,
  input logic                 beat_last,
  input logic                 rej_fire,
  input logic                 beat_fire,
  input logic                 burst_done,
  input logic [SZ_W-1:0]      size_q
);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
                                  $stable(beat_strb) && $stable(beat_last));

  // R6
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> req_ready && !beat_valid);

  // R7
  reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_fire |=> req_err && !beat_valid);

  // R5
  more_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last |=> beat_valid);

  // R3
  addr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last |=> beat_addr > $past(beat_addr));

  // R4
  strb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_strb != '0) && ($countones(beat_strb) <= (1 << size_q)));
endmodule

bind burst_beat_gen bbg_checker #(
  .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .SZ_W(SZ_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_err(req_err),
  .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
  .beat_strb(beat_strb), .beat_last(beat_last), .rej_fire(rej_fire),
  .beat_fire(beat_fire), .burst_done(burst_done), .size_q(size_q)
);

// File: tb/test_burst_beat_gen.sv
module test_burst_beat_gen;
  localparam int AW = 16;
  localparam int LW = 10;
  localparam int BB = 4;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [SW-1:0] req_size = '0;
  logic req_wrap = 1'b0;
  logic req_err;
  logic beat_valid;
  logic beat_ready = 1'b0;
  logic [AW-1:0] beat_addr;
  logic [BB-1:0] beat_strb;
  logic beat_last;

  always #5 clk = ~clk;

  burst_beat_gen #(.ADDR_W(AW), .LEN_W(LW), .BUS_BYTES(BB), .SZ_W(SW)) i_burst_beat_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_wrap(req_wrap),
    .req_err(req_err), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .beat_strb(beat_strb), .beat_last(beat_last)
  );

  typedef struct { int addr; int strb; bit last; } beat_t;
  beat_t q[$];
  bit exp_err = 0;
  int vectors = 0, fails = 0, cyc = 0;
  int cur_nb = 0, obs_n = 0;
  int obs_strb[64];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R6 watchdog actual=%0d expected=below 100000", cyc);
      summary();
      $finish;
    end
  end

  // reference model: builds the beat list byte by byte
  task automatic build(input int st, input int len, input int sz);
    int en, nb, usz;
    usz = 1 << sz;
    en  = st + len - 1;
    nb  = (en / usz) - (st / usz) + 1;
    cur_nb = nb;
    obs_n  = 0;
    for (int k = 0; k < nb; k++) begin
      beat_t b;
      int base;
      base = ((st / usz) + k) * usz;
      b.addr = (k == 0) ? st : base;
      b.strb = 0;
      for (int y = base; y < base + usz; y++)
        if (y >= st && y <= en) b.strb |= (1 << (y % BB));
      b.last = (k == nb - 1);
      q.push_back(b);
    end
  endtask

  function automatic bit refused(input int st, input int len, input int sz, input bit w);
    if (len == 0) return 1;
    if (sz > 2) return 1;
    if (w && (st % (1 << sz)) != 0) return 1;
    return 0;
  endfunction

  task automatic step(input bit rv, input int a, input int l, input int s, input bit w,
                      input bit br, output bit acc);
    @(negedge clk);
    chk(req_ready === (q.size() == 0), "R6 req_ready", req_ready, q.size() == 0);
    chk(beat_valid === (q.size() != 0), "R6 beat_valid", beat_valid, q.size() != 0);
    chk(req_err === exp_err, "R7 R8 R9 req_err", req_err, exp_err);
    if (q.size() != 0) begin
      chk(int'(beat_addr) == q[0].addr, "R2 R3 beat_addr", beat_addr, q[0].addr);
      chk(int'(beat_strb) == q[0].strb, "R4 beat_strb", beat_strb, q[0].strb);
      chk(beat_last === q[0].last, "R5 beat_last", beat_last, q[0].last);
    end
    req_valid  = rv;
    req_addr   = AW'(a);
    req_len    = LW'(l);
    req_size   = SW'(s);
    req_wrap   = w;
    beat_ready = br;
    if (beat_valid && br) begin
      if (obs_n < 64) obs_strb[obs_n] = int'(beat_strb);
      obs_n++;
      if (beat_last) chk(obs_n == cur_nb, "R1 beat count", obs_n, cur_nb);
    end
    @(posedge clk);
    acc = 0;
    exp_err = 0;
    if (q.size() != 0) begin
      if (br) void'(q.pop_front());
    end else if (rv) begin
      acc = 1;
      if (refused(a, l, s, w)) exp_err = 1;
      else build(a, l, s);
    end
  endtask

  task automatic run_req(input int a, input int l, input int s, input bit w, input bit rnd);
    bit acc = 0;
    while (!acc) step(1, a, l, s, w, rnd ? 1'($urandom_range(0, 1)) : 1'b1, acc);
    while (q.size() != 0 || exp_err)
      step(0, 0, 0, 0, 0, rnd ? 1'($urandom_range(0, 1)) : 1'b1, acc);
  endtask

  initial begin
    bit dummy;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset values
    chk(req_ready === 1'b1, "R11 req_ready", req_ready, 1);
    chk(beat_valid === 1'b0, "R11 beat_valid", beat_valid, 0);
    chk(req_err === 1'b0, "R11 req_err", req_err, 0);
    rst_n = 1'b1;

    // straddling word burst: 16 bytes from 0x01
    run_req(16'h0001, 16, 2, 0, 0);
    chk(obs_n == 5, "R1 five beats", obs_n, 5);
    chk(obs_strb[0] == 4'hE, "R2 first strobe", obs_strb[0], 4'hE);
    for (int k = 1; k < 4; k++)
      chk(obs_strb[k] == 4'hF, "R4 middle strobe", obs_strb[k], 4'hF);
    chk(obs_strb[4] == 4'h1, "R4 final strobe", obs_strb[4], 4'h1);
    step(0, 0, 0, 0, 0, 1, dummy);

    for (int pass = 0; pass < 2; pass++) begin
      bit rnd = (pass == 1);
      run_req(16'h0001, 16, 2, 0, rnd);
      run_req(16'h0010, 8, 2, 0, rnd);    // aligned, full strobes
      run_req(16'h0003, 5, 0, 0, rnd);    // byte beats, lane follows address
      run_req(16'h0005, 6, 1, 0, rnd);    // halfword beats from odd address
      run_req(16'h0022, 1, 2, 0, rnd);    // single byte, first beat is last (R5)
      run_req(16'h0103, 37, 2, 0, rnd);   // longer unaligned burst
      run_req(16'h0040, 0, 2, 0, rnd);    // R7 empty
      run_req(16'h0042, 8, 2, 1, rnd);    // R8 misaligned wrap
      run_req(16'h0050, 8, 3, 0, rnd);    // R9 too wide
      run_req(16'h0060, 16, 2, 1, rnd);   // R10 aligned wrap issued
      run_req(16'h0061, 7, 1, 1, rnd);    // R8 halfword misaligned wrap
      run_req(16'h0200, 3, 0, 1, rnd);    // R10 byte wrap always aligned
    end
    for (int n = 0; n < 20; n++)
      run_req(int'($urandom_range(0, 16'h7000)), int'($urandom_range(0, 60)),
              int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1);
    step(0, 0, 0, 0, 0, 1, dummy);
    summary();
    $finish;
  end
endmodule